// File: doc/BRIEF.md
# Dual-Pattern Telegram Start Detector

This block watches a serial stream of demodulated chips and flags the start of a telegram. Each chip arrives with a one-cycle valid strobe. The block holds two programmable patterns, A and B, each up to `PAT_W` chips long. A 2-bit mode input sets how the two patterns combine: concatenated into one long pattern, either one alone, A followed by B after a programmed gap, or either one alone with the matching pattern reported as the first data bit. A wildcard mask can turn the lowest chips of pattern A into don't-cares.

The detector raises `detect` for one cycle. After that it stays quiet until `restart` re-arms it, so the surrounding receiver has time to switch to payload handling. Chips that arrive while the detector is disarmed still enter its history window. A pattern can therefore complete from chips received before the re-arm.

Top module: `start_pattern_detector`

## Requirements
- R1: Chips enter a history window with the newest chip at index 0. A pattern of length L matches when the last L chips equal pattern bits L-1..0, with bit L-1 received first. `detect` goes high for exactly one cycle, in the cycle after the clock edge that takes the completing chip.
- R2: With `mode`=00, detection needs pattern A (all `PAT_W` bits) followed directly by pattern B (`len_b` chips) as one continuous sequence. This combination is active only when `len_a` equals 2*`PAT_W` and `len_b` is nonzero. Any other lengths never detect in this mode.
- R3: With `mode`=01, detection fires when pattern A (`len_a` chips) or pattern B (`len_b` chips) matches. A length of 0 or more than `PAT_W` disables that pattern.
- R4: With `mode`=10, a match of A starts a window of `gap_len` chips plus `len_b` chips. Detection fires only if B matches on the last chip of that window. If it does not, the attempt is dropped and the search for A resumes with the next chip. A matches are not acted on while a window is open.
- R5: With `mode`=11, either pattern detects. `first_bit` is 0 when A matched and 1 when B matched, and A wins when both match on the same chip. In the other modes `first_bit` is 0 with each detect.
- R6: Bit i of `wild_mask` (i < `MASK_W`) makes chip i of pattern A a don't-care in every mode. An all-zero mask needs every chip of A to match. Pattern B has no wildcards.
- R7: After a detect, further matches are ignored until a cycle with `restart`=1. A match whose completing chip arrives in the same cycle as `restart` is ignored, and it does not disarm the detector.
- R8: A pattern cannot match until at least as many chips as it covers have been received since reset.
- R9: During and right after reset, `detect` and `first_bit` are 0.
- R10: In mode 00, a failed attempt keeps the window contents. A second copy of A received right after a first A that is not followed by B still leads to a detect once B follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_vld | input | 1 | Strobe: `chip` carries a new chip this cycle |
| chip | input | 1 | Demodulated chip value |
| restart | input | 1 | Re-arms detection after a detect |
| mode | input | 2 | 00 concatenated, 01 either, 10 gap, 11 either with report |
| pat_a | input | PAT_W | Pattern A, bit 0 is the last chip |
| pat_b | input | PAT_W | Pattern B, bit 0 is the last chip |
| len_a | input | clog2(2*PAT_W+1) | Length of A; 2*PAT_W selects concatenation in mode 00 |
| len_b | input | clog2(PAT_W+1) | Length of B |
| wild_mask | input | MASK_W | Don't-care mask for the low chips of A |
| gap_len | input | GAP_W | Gap in chips between A and B in mode 10 |
| detect | output | 1 | One-cycle start detect pulse |
| first_bit | output | 1 | First data bit reported with a detect in mode 11 |

## Verification
Two events can land in the same cycle. The first is A and B completing on the same chip in the reporting mode. The bench provokes it by loading both patterns with the same value and expects `first_bit` to be 0. The second is `restart` arriving together with the chip that completes a match. The bench drives both in one cycle and expects no pulse. It then confirms that the detector is still armed: a fresh copy of the pattern is sent and must detect.

// File: rtl/start_pattern_detector.sv
module start_pattern_detector #(
  parameter int PAT_W  = 8,
  parameter int MASK_W = 4,
  parameter int GAP_W  = 8,
  localparam int SR_W  = 2 * PAT_W,
  localparam int LA_W  = $clog2(SR_W + 1),
  localparam int LB_W  = $clog2(PAT_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_vld,
  input  logic              chip,
  input  logic              restart,
  input  logic [1:0]        mode,
  input  logic [PAT_W-1:0]  pat_a,
  input  logic [PAT_W-1:0]  pat_b,
  input  logic [LA_W-1:0]   len_a,
  input  logic [LB_W-1:0]   len_b,
  input  logic [MASK_W-1:0] wild_mask,
  input  logic [GAP_W-1:0]  gap_len,
  output logic              detect,
  output logic              first_bit
);

  localparam int CNT_W = GAP_W + 1;
  localparam logic [1:0] M_CAT = 2'b00, M_GAP = 2'b10, M_REP = 2'b11;

  logic [SR_W-1:0]  sr, sr_nxt;
  logic [LA_W-1:0]  fill, fill_nxt;
  logic [CNT_W-1:0] cnt;
  logic [PAT_W-1:0] wmask;
  logic             locked, a_len_ok, b_len_ok, a_hit, b_hit, cat_hit, fire, go;

  function automatic logic hit(input logic [SR_W-1:0] s, input logic [PAT_W-1:0] p,
                               input logic [PAT_W-1:0] dc, input int len, input int off);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < PAT_W; i++)
      if (i < len && off + i < SR_W && s[off+i] != p[i] && !dc[i]) ok = 1'b0;
    return ok;
  endfunction

  assign wmask    = PAT_W'(wild_mask);
  assign sr_nxt   = {sr[SR_W-2:0], chip};
  assign fill_nxt = (int'(fill) == SR_W) ? fill : fill + 1'b1;
  assign a_len_ok = int'(len_a) != 0 && int'(len_a) <= PAT_W;
  assign b_len_ok = int'(len_b) != 0 && int'(len_b) <= PAT_W;

  assign a_hit = a_len_ok && int'(fill_nxt) >= int'(len_a)
                 && hit(sr_nxt, pat_a, wmask, int'(len_a), 0);
  assign b_hit = b_len_ok && int'(fill_nxt) >= int'(len_b)
                 && hit(sr_nxt, pat_b, '0, int'(len_b), 0);
  assign cat_hit = int'(len_a) == SR_W && b_len_ok
                   && int'(fill_nxt) >= PAT_W + int'(len_b)
                   && hit(sr_nxt, pat_b, '0, int'(len_b), 0)
                   && hit(sr_nxt, pat_a, wmask, PAT_W, int'(len_b));

  always_comb begin
    case (mode)
      M_CAT:   fire = cat_hit;
      M_GAP:   fire = (cnt == CNT_W'(1)) && b_hit;
      default: fire = a_hit || b_hit;
    endcase
  end

  assign go = chip_vld && !locked && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      fill      <= '0;
      cnt       <= '0;
      locked    <= 1'b0;
      detect    <= 1'b0;
      first_bit <= 1'b0;
    end else begin
      detect <= go && fire;
      if (chip_vld) begin
        sr   <= sr_nxt;
        fill <= fill_nxt;
      end
      if (go && fire) begin
        locked    <= 1'b1;
        first_bit <= (mode == M_REP) && !a_hit;
      end else if (restart) begin
        locked <= 1'b0;
      end
      if (restart || mode != M_GAP || locked)
        cnt <= '0;
      else if (chip_vld) begin
        if (cnt != '0)
          cnt <= cnt - 1'b1;
        else if (a_hit && b_len_ok)
          cnt <= CNT_W'(gap_len) + CNT_W'(len_b);
      end
    end
  end

endmodule

module start_pattern_detector_chk #(
  parameter int PAT_W = 8,
  localparam int SR_W = 2 * PAT_W,
  localparam int LA_W = $clog2(SR_W + 1),
  localparam int LB_W = $clog2(PAT_W + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            chip_vld,
  input logic            restart,
  input logic [1:0]      mode,
  input logic [LA_W-1:0] len_a,
  input logic [LB_W-1:0] len_b,
  input logic            detect,
  input logic            first_bit,
  input logic            locked
);

  // R1
  from_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect |-> $past(chip_vld));

  // R7
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect |=> !detect);

  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !detect);

  // R7
  disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> !detect);

  // R2
  cat_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (detect && $past(mode) == 2'b00) |-> (int'($past(len_a)) == SR_W && $past(len_b) != '0));

  // R5
  report_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (detect && $past(mode) != 2'b11) |-> !first_bit);

endmodule

bind start_pattern_detector start_pattern_detector_chk #(.PAT_W(PAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_vld(chip_vld), .restart(restart), .mode(mode),
  .len_a(len_a), .len_b(len_b), .detect(detect), .first_bit(first_bit), .locked(locked)
);

// File: tb/test_start_pattern_detector.sv
module test_start_pattern_detector;
  localparam int CLK_PERIOD = 10;
  localparam int PAT_W = 8;

  logic       clk = 1'b0, rst_n = 1'b0, chip_vld = 1'b0, chip = 1'b0, restart = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [7:0] pat_a = 8'h00, pat_b = 8'hFF, gap_len = 8'd3;
  logic [4:0] len_a = 5'd8;
  logic [3:0] len_b = 4'd8, wild_mask = 4'h0;
  logic       detect, first_bit;

  typedef struct {logic det; logic fb; logic cf; string rq;} exp_t;
  exp_t q[$];
  exp_t cur;
  int vectors = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  start_pattern_detector #(.PAT_W(PAT_W)) i_start_pattern_detector (
    .clk(clk), .rst_n(rst_n), .chip_vld(chip_vld), .chip(chip), .restart(restart),
    .mode(mode), .pat_a(pat_a), .pat_b(pat_b), .len_a(len_a), .len_b(len_b),
    .wild_mask(wild_mask), .gap_len(gap_len), .detect(detect), .first_bit(first_bit)
  );

  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      cur = q.pop_front();
      vectors++;
      if (detect !== cur.det) begin
        fails++;
        $display("FAIL %s: detect=%b expected %b", cur.rq, detect, cur.det);
      end else if (cur.det && cur.cf && first_bit !== cur.fb) begin
        fails++;
        $display("FAIL %s: first_bit=%b expected %b", cur.rq, first_bit, cur.fb);
      end
    end
  end

  task automatic step(input logic v, input logic c, input logic rs, input logic ed,
                      input logic ef, input logic cf, input string rq);
    @(negedge clk);
    chip_vld = v; chip = c; restart = rs;
    q.push_back('{ed, ef, cf, rq});
  endtask

  task automatic idle(input string rq);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, rq);
  endtask

  task automatic rearm();
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
  endtask

  task automatic send(input logic [7:0] v, input logic ed, input logic ef, input string rq);
    for (int i = 7; i >= 0; i--)
      step(1'b1, v[i], 1'b0, (i == 0) ? ed : 1'b0, ef, 1'b1, rq);
  endtask

  task automatic zeros(input int n, input string rq);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R9 reset state
    idle("R9"); idle("R9");
    q[q.size()-1].cf = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    idle("R9");

    // R8: all-zero pattern A only after 8 chips
    send(8'h00, 1'b1, 1'b0, "R8");
    zeros(8, "R7");
    rearm();
    pat_a = 8'hB4; pat_b = 8'h3C;

    // R1 R3: pattern A in either mode
    send(8'hB4, 1'b1, 1'b0, "R1 R3");
    // R7: locked, second copy ignored
    send(8'hB4, 1'b0, 1'b0, "R7");
    zeros(8, "R7"); rearm();
    send(8'h3C, 1'b1, 1'b0, "R3");
    zeros(8, "R7"); rearm();

    // R5 reporting mode
    mode = 2'b11;
    send(8'hB4, 1'b1, 1'b0, "R5");
    zeros(8, "R7"); rearm();
    send(8'h3C, 1'b1, 1'b1, "R5");
    zeros(8, "R7"); rearm();
    pat_b = 8'hB4;
    send(8'hB4, 1'b1, 1'b0, "R5 priority");
    zeros(8, "R7"); rearm();
    pat_b = 8'h3C;

    // R7: restart with the completing chip
    for (int i = 7; i >= 1; i--) step(1'b1, 1'(8'hB4 >> i), 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    zeros(8, "R7");
    send(8'hB4, 1'b1, 1'b0, "R7");
    zeros(8, "R7"); rearm();

    // R6 wildcards
    mode = 2'b01; wild_mask = 4'hF;
    send(8'hB3, 1'b1, 1'b0, "R6");
    zeros(8, "R7"); rearm();
    wild_mask = 4'h1;
    send(8'hB6, 1'b0, 1'b0, "R6");
    zeros(8, "R6");
    send(8'hB5, 1'b1, 1'b0, "R6");
    zeros(8, "R7"); rearm();
    wild_mask = 4'h0; mode = 2'b00;

    // R2 concatenated mode and its length rules
    send(8'hB4, 1'b0, 1'b0, "R2"); send(8'h3C, 1'b0, 1'b0, "R2");
    idle("R2"); len_a = 5'd16;
    zeros(16, "R2");
    idle("R2"); len_b = 4'd0;
    send(8'hB4, 1'b0, 1'b0, "R2"); send(8'h3C, 1'b0, 1'b0, "R2");
    zeros(16, "R2");
    idle("R2"); len_b = 4'd8;
    send(8'hB4, 1'b0, 1'b0, "R2"); send(8'h3C, 1'b1, 1'b0, "R2");
    zeros(16, "R7"); rearm();

    // R10 retry keeps window
    send(8'hB4, 1'b0, 1'b0, "R10"); send(8'hB4, 1'b0, 1'b0, "R10");
    send(8'h3C, 1'b1, 1'b0, "R10");
    zeros(16, "R7"); rearm();
    len_a = 5'd8; mode = 2'b10;

    // R4 gap mode: abort then success
    send(8'hB4, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    send(8'h3D, 1'b0, 1'b0, "R4");
    send(8'hB4, 1'b0, 1'b0, "R4");
    zeros(3, "R4");
    send(8'h3C, 1'b1, 1'b0, "R4");
    idle("R7");

    wait (q.size() == 0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule